// File: doc/BRIEF.md
# Serial Receiver with Per-Entry Error Queue

This block turns an asynchronous serial line into bytes. A baud tick running at sixteen times the bit rate drives a deserializer that supports 5 to 8 data bits, an optional parity bit (odd, even, or a fixed 1 or 0) and one or two stop bits. Every received character goes into a 64-deep queue. Each queue entry stores the byte together with its own four error flags: overrun, parity, frame and break. The error flags for a character therefore surface only when that character reaches the read side.

A consumer reads the byte at the queue head through a read strobe. The head's error flags are visible on a separate port at the same time, and a pop removes byte and flags together. Three interrupt outputs are provided:
- a receive pulse when the queue fill reaches a selectable level;
- a timeout level when characters sit unread on an idle line;
- an error level when the head entry carries a flag.

With queueing switched off, the store behaves as a single holding register.

Top module: `serial_rx_tagged`

## Requirements
- R1: After reset, rx_count is 0, rx_full is 0 and irq_rx, irq_tmo and irq_err are all 0.
- R2: cfg_wlen selects the data width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive LSB first and are presented right-aligned on rd_data, with the unused upper bits at 0. cfg_two_stop=1 expects two stop bits and cfg_two_stop=0 expects one.
- R3: cfg_parity selects the parity check:
  - 0xx: no parity bit.
  - 100: odd parity.
  - 101: even parity.
  - 110: the parity bit must be 1.
  - 111: the parity bit must be 0.

  A mismatch sets error bit 1 of that entry.
- R4: A stop bit sampled as 0 sets error bit 2 (frame) of the entry. After such a frame the receiver waits for the line to return high before it accepts a new start bit.
- R5: When the data bits, the parity bit and every stop bit of a frame are all 0 (the line stays low for a whole frame), the entry holds data 0 with bit 3 (break) and bit 2 (frame) set.
- R6: A falling edge whose line is high again at the 8th tick (mid start bit) is discarded and stores no entry.
- R7: Entries are read in arrival order, one per rd_data_en pulse. rd_data_en with an empty queue has no effect. rx_count shows the occupancy modulo 64. rx_full is 1 exactly when 64 entries are held, and rx_count then reads 0.
- R8: A character that arrives while the store is full replaces the newest entry and sets error bit 0 (overrun) there. Full means 64 entries when cfg_fifo_en=1 and 1 entry when cfg_fifo_en=0.
- R9: irq_rx is a one-cycle pulse in the cycle after a character is stored.
  - With cfg_fifo_en=1, it fires only when the store brings the occupancy to the trigger level. cfg_trig selects the level: 00 is 1, 01 is 8, 10 is 16 and 11 is 32.
  - With cfg_fifo_en=0, every arriving character fires it, including an overwrite.
- R10: With cfg_fifo_en=1 and cfg_tmo_en=1, irq_tmo rises when the queue is non-empty and no character has been stored or popped for 3 frame times. A frame time is 16 ticks for each frame bit. A pop clears irq_tmo, and irq_tmo stays 0 when cfg_tmo_en=0.
- R11: irq_err is 1 while cfg_err_en=1 and the head entry's flags on rd_err are non-zero. The flags are bit 3 break, bit 2 frame, bit 1 parity and bit 0 overrun. Popping the entry clears them.
- R12: A one-cycle fifo_flush pulse empties the store, so rx_count and rx_full read 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_wlen | input | 2 | Data width code |
| cfg_parity | input | 3 | Parity mode code |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_fifo_en | input | 1 | 64-deep queue when 1, single holding entry when 0 |
| cfg_trig | input | 2 | Receive trigger level code |
| cfg_tmo_en | input | 1 | Idle timeout enable |
| cfg_err_en | input | 1 | Error interrupt enable |
| fifo_flush | input | 1 | Pulse that empties the store |
| rd_data_en | input | 1 | Pops the head entry |
| rd_data | output | 8 | Head entry byte |
| rd_err | output | 4 | Head entry error flags |
| rx_count | output | 6 | Occupancy modulo 64 |
| rx_full | output | 1 | 64 entries held |
| irq_rx | output | 1 | Trigger-level pulse |
| irq_tmo | output | 1 | Idle timeout level |
| irq_err | output | 1 | Head-entry error level |

## Verification
A character is stored three clock cycles after the line is sampled in mid stop bit: two synchronizer flops, then the deserializer's output register. irq_rx follows one cycle later. rd_data, rd_err and irq_err follow the head entry combinationally, so they change in the cycle after a pop, and irq_tmo is due 3×16×(frame bits) ticks after the last store or pop. The bench therefore drives and samples only on falling edges. It waits two idle bit times after each stop bit before reading, and it brackets the timeout with one check well before the limit and one well after it.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int OVS       = 16;
    localparam int HALF      = OVS / 2;
    localparam int MAX_FRAME = 12;
    localparam int TMO_W     = $clog2(3 * OVS * MAX_FRAME + 1);

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } err_t;

    typedef struct packed {
        err_t       err;
        logic [7:0] data;
    } entry_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2, ST_HOLD
    } rx_state_t;

    function automatic int frame_bits(logic [1:0] wl, logic [2:0] par, logic ts);
        return 1 + 5 + int'(wl) + int'(par[2]) + 1 + int'(ts);
    endfunction

    function automatic int trig_level(logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic parity_ok(logic [2:0] par, logic data_xor, logic pbit);
        case (par[1:0])
            2'b00:   return (data_xor ^ pbit) == 1'b1;
            2'b01:   return (data_xor ^ pbit) == 1'b0;
            2'b10:   return pbit == 1'b1;
            default: return pbit == 1'b0;
        endcase
    endfunction

    function automatic entry_t make_entry(logic [7:0] sh, logic [1:0] wl,
                                          logic perr, logic ferr, logic brk);
        entry_t e;
        e.data    = sh >> (2'd3 - wl);
        e.err.brk = brk;
        e.err.frm = ferr;
        e.err.par = perr;
        e.err.ovr = 1'b0;
        return e;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE_LEVEL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_deser.sv
module srx_deser
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] wl,
    input  logic [2:0] par,
    input  logic       two_stop,
    output logic       push,
    output entry_t     word
);
    localparam int TW = $clog2(OVS);

    rx_state_t      st;
    logic [TW-1:0]  tcnt;
    logic [2:0]     bitn;
    logic [7:0]     shreg;
    logic           perr;
    logic           zero;
    logic           stop1_low;
    logic           slot_end;
    logic           half_end;
    logic           stop2_bad;
    logic           stop2_brk;

    assign slot_end  = tick && (tcnt == TW'(OVS - 1));
    assign half_end  = tick && (tcnt == TW'(HALF - 1));
    assign stop2_bad = stop1_low | ~rx;
    assign stop2_brk = zero & stop1_low & ~rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            tcnt      <= '0;
            bitn      <= '0;
            shreg     <= '0;
            perr      <= 1'b0;
            zero      <= 1'b0;
            stop1_low <= 1'b0;
            push      <= 1'b0;
            word      <= '0;
        end else begin
            push <= 1'b0;
            if (tick) tcnt <= tcnt + 1'b1;
            case (st)
                ST_IDLE: begin
                    tcnt <= '0;
                    if (tick && !rx) st <= ST_START;
                end
                ST_START: begin
                    if (half_end) begin
                        tcnt <= '0;
                        if (rx) begin
                            st <= ST_IDLE;
                        end else begin
                            st    <= ST_DATA;
                            bitn  <= '0;
                            shreg <= '0;
                            perr  <= 1'b0;
                            zero  <= 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (slot_end) begin
                        tcnt  <= '0;
                        shreg <= {rx, shreg[7:1]};
                        zero  <= zero & ~rx;
                        if (bitn == 3'(4 + int'(wl))) st <= par[2] ? ST_PAR : ST_STOP;
                        else                         bitn <= bitn + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (slot_end) begin
                        tcnt <= '0;
                        perr <= !parity_ok(par, ^shreg, rx);
                        zero <= zero & ~rx;
                        st   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (slot_end) begin
                        tcnt <= '0;
                        if (two_stop) begin
                            stop1_low <= ~rx;
                            st        <= ST_STOP2;
                        end else begin
                            push <= 1'b1;
                            word <= make_entry(shreg, wl, perr, ~rx, zero & ~rx);
                            st   <= rx ? ST_IDLE : ST_HOLD;
                        end
                    end
                end
                ST_STOP2: begin
                    if (slot_end) begin
                        tcnt <= '0;
                        push <= 1'b1;
                        word <= make_entry(shreg, wl, perr, stop2_bad, stop2_brk);
                        st   <= stop2_bad ? ST_HOLD : ST_IDLE;
                    end
                end
                ST_HOLD: begin
                    tcnt <= '0;
                    if (rx) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        fifo_en,
    input  logic        push,
    input  entry_t      din,
    input  logic        pop,
    output entry_t      head,
    output logic [AW:0] occ,
    output logic        stored,
    output logic        ovwr,
    output logic        popped
);
    entry_t          mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   rptr;
    logic [AW:0]     cap;
    logic            full_now;
    entry_t          ovr_word;

    assign cap      = fifo_en ? (AW+1)'(DEPTH) : (AW+1)'(1);
    assign full_now = occ >= cap;
    assign popped   = pop && (occ != '0);
    assign stored   = push && (!full_now || popped);
    assign ovwr     = push && full_now && !popped;

    always_comb begin
        ovr_word         = din;
        ovr_word.err.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (stored)    mem[wptr]        <= din;
        else if (ovwr) mem[wptr - 1'b1] <= ovr_word;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (stored) wptr <= wptr + 1'b1;
            if (popped) rptr <= rptr + 1'b1;
            case ({stored, popped})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign head = mem[rptr];
endmodule

// File: rtl/srx_irq.sv
module srx_irq
    import srx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        fifo_en,
    input  logic [1:0]  trig,
    input  logic        tmo_en,
    input  logic        err_en,
    input  logic [1:0]  wl,
    input  logic [2:0]  par,
    input  logic        two_stop,
    input  logic        flush,
    input  logic        stored,
    input  logic        ovwr,
    input  logic        popped,
    input  logic [AW:0] occ,
    input  err_t        head_err,
    output logic        irq_rx,
    output logic        irq_tmo,
    output logic        irq_err
);
    logic             stored_q;
    logic             ovwr_q;
    logic [TMO_W-1:0] idle_cnt;
    logic [TMO_W-1:0] limit;
    logic             restart;
    logic             nonempty;

    assign nonempty = occ != '0;
    assign limit    = TMO_W'(3 * OVS * frame_bits(wl, par, two_stop));
    assign restart  = stored | ovwr | popped | flush | !nonempty | !fifo_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= 1'b0;
            ovwr_q   <= 1'b0;
        end else begin
            stored_q <= stored;
            ovwr_q   <= ovwr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart)                idle_cnt <= '0;
        else if (tick && idle_cnt < limit) idle_cnt <= idle_cnt + 1'b1;
    end

    assign irq_rx  = fifo_en ? (stored_q && occ == (AW+1)'(trig_level(trig)))
                             : (stored_q || ovwr_q);
    assign irq_tmo = tmo_en && fifo_en && nonempty && (idle_cnt >= limit);
    assign irq_err = err_en && nonempty && (head_err != '0);
endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
    import srx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  logic          rxd,
    input  logic [1:0]    cfg_wlen,
    input  logic [2:0]    cfg_parity,
    input  logic          cfg_two_stop,
    input  logic          cfg_fifo_en,
    input  logic [1:0]    cfg_trig,
    input  logic          cfg_tmo_en,
    input  logic          cfg_err_en,
    input  logic          fifo_flush,
    input  logic          rd_data_en,
    output logic [7:0]    rd_data,
    output logic [3:0]    rd_err,
    output logic [AW-1:0] rx_count,
    output logic          rx_full,
    output logic          irq_rx,
    output logic          irq_tmo,
    output logic          irq_err
);
    logic        rx_s;
    logic        deser_push;
    entry_t      deser_word;
    entry_t      head;
    logic [AW:0] occ;
    logic        stored;
    logic        ovwr;
    logic        popped;

    srx_sync #(.STAGES(2), .IDLE_LEVEL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_s)
    );

    srx_deser u_deser (
        .clk(clk), .rst(rst), .tick(baud_tick), .rx(rx_s),
        .wl(cfg_wlen), .par(cfg_parity), .two_stop(cfg_two_stop),
        .push(deser_push), .word(deser_word)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(fifo_flush), .fifo_en(cfg_fifo_en),
        .push(deser_push), .din(deser_word), .pop(rd_data_en),
        .head(head), .occ(occ), .stored(stored), .ovwr(ovwr), .popped(popped)
    );

    srx_irq #(.DEPTH(DEPTH)) u_irq (
        .clk(clk), .rst(rst), .tick(baud_tick), .fifo_en(cfg_fifo_en),
        .trig(cfg_trig), .tmo_en(cfg_tmo_en), .err_en(cfg_err_en),
        .wl(cfg_wlen), .par(cfg_parity), .two_stop(cfg_two_stop),
        .flush(fifo_flush), .stored(stored), .ovwr(ovwr), .popped(popped),
        .occ(occ), .head_err(head.err),
        .irq_rx(irq_rx), .irq_tmo(irq_tmo), .irq_err(irq_err)
    );

    assign rd_data  = head.data;
    assign rd_err   = head.err;
    assign rx_count = occ[AW-1:0];
    assign rx_full  = occ[AW];
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_flush,
    input logic          rd_data_en,
    input logic          push,
    input logic          cfg_err_en,
    input logic [AW-1:0] rx_count,
    input logic          rx_full,
    input logic [3:0]    rd_err,
    input logic          irq_rx,
    input logic          irq_tmo,
    input logic          irq_err
);
    logic [AW:0] occ;
    assign occ = {rx_full, rx_count};

    // R1
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (occ == '0 && !irq_tmo && !irq_err));

    // R12
    assert_flush_clears_R12: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> (occ == '0));

    // R7
    assert_pop_step_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_data_en && occ != '0 && !push && !fifo_flush) |=> (occ == $past(occ) - 1'b1));

    // R7
    assert_full_count_R7: assert property (@(posedge clk) disable iff (rst)
        rx_full |-> (rx_count == '0));

    // R9
    assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        irq_rx |=> !irq_rx);

    // R10
    assert_tmo_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
        irq_tmo |-> (occ != '0));

    // R11
    assert_err_head_R11: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> (cfg_err_en && rd_err != 4'h0));
endmodule

bind serial_rx_tagged srx_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .fifo_flush(fifo_flush), .rd_data_en(rd_data_en),
    .push(deser_push), .cfg_err_en(cfg_err_en), .rx_count(rx_count),
    .rx_full(rx_full), .rd_err(rd_err), .irq_rx(irq_rx), .irq_tmo(irq_tmo),
    .irq_err(irq_err)
);

// File: tb/serial_rx_tagged_test.sv
module serial_rx_tagged_test;

    localparam int BIT_CLKS = 64;
    localparam int NVEC     = 9;

    typedef struct packed {
        logic [1:0] wl;
        logic [2:0] par;
        logic       ts;
        logic [7:0] dat;
        logic       flip;
        logic       bad;
        logic [7:0] exp_d;
        logic [3:0] exp_e;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 3'b000, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 4'h0},
        '{2'd0, 3'b100, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h1F, 4'h0},
        '{2'd1, 3'b101, 1'b1, 8'h2C, 1'b0, 1'b0, 8'h2C, 4'h0},
        '{2'd2, 3'b100, 1'b0, 8'h55, 1'b1, 1'b0, 8'h55, 4'h2},
        '{2'd3, 3'b110, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 4'h0},
        '{2'd3, 3'b111, 1'b0, 8'h81, 1'b1, 1'b0, 8'h81, 4'h2},
        '{2'd3, 3'b000, 1'b0, 8'h7E, 1'b0, 1'b1, 8'h7E, 4'h4},
        '{2'd3, 3'b101, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 4'h4},
        '{2'd0, 3'b011, 1'b1, 8'h0A, 1'b0, 1'b0, 8'h0A, 4'h0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic [2:0] cfg_parity = 3'b000;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_fifo_en = 1'b1;
    logic [1:0] cfg_trig = 2'd0;
    logic       cfg_tmo_en = 1'b0;
    logic       cfg_err_en = 1'b0;
    logic       fifo_flush = 1'b0;
    logic       rd_data_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] rd_err;
    logic [5:0] rx_count;
    logic       rx_full;
    logic       irq_rx;
    logic       irq_tmo;
    logic       irq_err;

    int checks = 0;
    int fails  = 0;
    int rxp    = 0;

    serial_rx_tagged uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_fifo_en(cfg_fifo_en), .cfg_trig(cfg_trig), .cfg_tmo_en(cfg_tmo_en),
        .cfg_err_en(cfg_err_en), .fifo_flush(fifo_flush), .rd_data_en(rd_data_en),
        .rd_data(rd_data), .rd_err(rd_err), .rx_count(rx_count), .rx_full(rx_full),
        .irq_rx(irq_rx), .irq_tmo(irq_tmo), .irq_err(irq_err)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    always @(negedge clk) if (irq_rx === 1'b1) rxp <= rxp + 1;

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_wait;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [1:0] wl, input logic [2:0] par, input logic ts,
                              input logic [7:0] d, input logic flip, input logic bad);
        logic [7:0] mask;
        logic       xr;
        logic       p;
        mask = 8'hFF >> (2'd3 - wl);
        xr   = ^(d & mask);
        rxd  = 1'b0;
        bit_wait();
        for (int i = 0; i < 5 + int'(wl); i++) begin
            rxd = d[i];
            bit_wait();
        end
        if (par[2]) begin
            case (par[1:0])
                2'b00:   p = ~xr;
                2'b01:   p = xr;
                2'b10:   p = 1'b1;
                default: p = 1'b0;
            endcase
            rxd = p ^ flip;
            bit_wait();
        end
        rxd = ~bad;
        bit_wait();
        if (ts) begin
            rxd = 1'b1;
            bit_wait();
        end
        rxd = 1'b1;
        repeat (2) bit_wait();
    endtask

    task automatic pop;
        @(negedge clk);
        rd_data_en = 1'b1;
        @(negedge clk);
        rd_data_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic flush;
        @(negedge clk);
        fifo_flush = 1'b1;
        @(negedge clk);
        fifo_flush = 1'b0;
    endtask

    task automatic set8n1;
        cfg_wlen = 2'd3;
        cfg_parity = 3'b000;
        cfg_two_stop = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        int snap;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 count", 16'(rx_count), 16'h0);
        chk("R1 full", 16'(rx_full), 16'h0);
        chk("R1 irqs", 16'({irq_rx, irq_tmo, irq_err}), 16'h0);

        // Table: R2 widths, R3 parity modes, R4 frame errors, R9 level-1 trigger
        for (int v = 0; v < NVEC; v++) begin
            cfg_wlen = VECS[v].wl;
            cfg_parity = VECS[v].par;
            cfg_two_stop = VECS[v].ts;
            snap = rxp;
            send_frame(VECS[v].wl, VECS[v].par, VECS[v].ts, VECS[v].dat, VECS[v].flip, VECS[v].bad);
            chk($sformatf("R2 count vec%0d", v), 16'(rx_count), 16'h1);
            chk($sformatf("R2 data vec%0d", v), 16'(rd_data), 16'(VECS[v].exp_d));
            chk($sformatf("R3 R4 err vec%0d", v), 16'(rd_err), 16'(VECS[v].exp_e));
            chk($sformatf("R9 pulse vec%0d", v), 16'(rxp - snap), 16'h1);
            pop();
        end

        // R6 glitch start
        set8n1();
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (12) bit_wait();
        chk("R6 glitch ignored", 16'(rx_count), 16'h0);

        // R5 break
        rxd = 1'b0;
        repeat (12) bit_wait();
        rxd = 1'b1;
        repeat (3) bit_wait();
        chk("R5 break count", 16'(rx_count), 16'h1);
        chk("R5 break data", 16'(rd_data), 16'h0);
        chk("R5 break flags", 16'(rd_err), 16'hC);
        pop();

        // R11 error interrupt follows the head entry
        cfg_err_en = 1'b1;
        send_frame(2'd3, 3'b000, 1'b0, 8'h12, 1'b0, 1'b0);
        cfg_parity = 3'b101;
        send_frame(2'd3, 3'b101, 1'b0, 8'h34, 1'b1, 1'b0);
        chk("R11 good head no irq", 16'(irq_err), 16'h0);
        chk("R11 good head flags", 16'(rd_err), 16'h0);
        pop();
        chk("R11 bad head irq", 16'(irq_err), 16'h1);
        chk("R11 bad head flags", 16'(rd_err), 16'h2);
        chk("R11 bad head data", 16'(rd_data), 16'h34);
        cfg_err_en = 1'b0;
        @(negedge clk);
        chk("R11 disabled", 16'(irq_err), 16'h0);
        cfg_err_en = 1'b1;
        pop();
        chk("R11 cleared by pop", 16'(irq_err), 16'h0);
        set8n1();

        // R10 timeout
        cfg_tmo_en = 1'b1;
        send_frame(2'd3, 3'b000, 1'b0, 8'h5A, 1'b0, 1'b0);
        repeat (1500) @(negedge clk);
        chk("R10 early low", 16'(irq_tmo), 16'h0);
        repeat (400) @(negedge clk);
        chk("R10 fires", 16'(irq_tmo), 16'h1);
        pop();
        chk("R10 pop clears", 16'(irq_tmo), 16'h0);
        cfg_tmo_en = 1'b0;
        send_frame(2'd3, 3'b000, 1'b0, 8'h5B, 1'b0, 1'b0);
        repeat (2500) @(negedge clk);
        chk("R10 disabled", 16'(irq_tmo), 16'h0);
        pop();

        // R8 holding mode overrun, R9 pulse on every arrival
        cfg_fifo_en = 1'b0;
        snap = rxp;
        send_frame(2'd3, 3'b000, 1'b0, 8'h11, 1'b0, 1'b0);
        send_frame(2'd3, 3'b000, 1'b0, 8'h22, 1'b0, 1'b0);
        chk("R8 hold count", 16'(rx_count), 16'h1);
        chk("R8 hold data", 16'(rd_data), 16'h22);
        chk("R8 hold flags", 16'(rd_err), 16'h1);
        chk("R9 hold pulses", 16'(rxp - snap), 16'h2);
        pop();
        chk("R7 hold empty", 16'(rx_count), 16'h0);

        // R7 fill, R9 level 32, R8 overrun in queue mode
        cfg_fifo_en = 1'b1;
        cfg_trig = 2'd3;
        snap = rxp;
        for (int i = 0; i < 64; i++) send_frame(2'd3, 3'b000, 1'b0, 8'(8'h40 + i), 1'b0, 1'b0);
        chk("R7 full flag", 16'(rx_full), 16'h1);
        chk("R7 full count", 16'(rx_count), 16'h0);
        chk("R9 trig32 pulses", 16'(rxp - snap), 16'h1);
        send_frame(2'd3, 3'b000, 1'b0, 8'h99, 1'b0, 1'b0);
        chk("R8 still full", 16'(rx_full), 16'h1);
        chk("R9 no pulse on overwrite", 16'(rxp - snap), 16'h1);
        chk("R7 first out", 16'(rd_data), 16'h40);
        for (int i = 0; i < 63; i++) begin
            if (i == 31) chk("R7 order mid", 16'(rd_data), 16'h5F);
            pop();
        end
        chk("R8 newest replaced", 16'(rd_data), 16'h99);
        chk("R8 overrun flag", 16'(rd_err), 16'h1);
        pop();
        chk("R7 drained", 16'({rx_full, rx_count}), 16'h0);
        pop();
        chk("R7 empty pop ignored", 16'(rx_count), 16'h0);
        cfg_trig = 2'd0;
        send_frame(2'd3, 3'b000, 1'b0, 8'hC3, 1'b0, 1'b0);
        chk("R7 after empty pop", 16'(rd_data), 16'hC3);

        // R12 flush
        send_frame(2'd3, 3'b000, 1'b0, 8'hC4, 1'b0, 1'b0);
        chk("R12 before flush", 16'(rx_count), 16'h2);
        flush();
        chk("R12 flushed", 16'({rx_full, rx_count}), 16'h0);

        report();
        $finish;
    end
endmodule